// File: doc/BRIEF.md
# Word-Wide NOR Flash Command Sequencer

This block sits on the device side of a word-wide NOR flash array model. It watches the host's write cycles and accepts a change to the array only through a keyed command sequence. A four-write sequence programs one word. A six-write sequence erases the whole array. Any write that breaks a sequence drops the decoder back to read mode.

Once a sequence completes, an internal timed operation runs with no further help from the host. While it runs, `ready` is low, writes are ignored and every read returns a status word. When the operation finishes, the block returns to plain reads of the stored array.

Programming can only clear bits: the stored word becomes the old word AND the new data. A chip erase first clears every word to zero, one word per cycle. It then waits a fixed erase time and sets every word to all ones.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: While `rst` is high, the sequencer returns to read mode and `ready` goes high. Outside an operation, a read with `rd_en` high places the stored word at `rd_addr` on `rd_data` one cycle later.
- R2: The four writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (target, data) start a program. `ready` is low for exactly PROG_CYCLES cycles after the edge of the final write. A command write matches on the low 11 address bits and the low 8 data bits.
- R3: After a program completes, the target word holds the previous content AND the written data.
- R4: The six writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10) start a chip erase. `ready` is low for 2^ADDR_W + ERASE_CYCLES cycles. Afterwards every word reads all ones.
- R5: During a program, a status read returns bit 7 as the inverse of bit 7 of the written data. Bits 15..8 and 5..0 read zero.
- R6: During a chip erase, a status read returns bit 7 as zero.
- R7: Bit 6 of the status word flips on each successive status read while an operation runs.
- R8: A write that does not match the next expected step of a sequence returns the decoder to read mode. A later lone data write then programs nothing, and no operation starts.
- R9: Writes received while `ready` is low have no effect: they start no operation, do not advance the decoder and do not change the operation's duration.
- R10: Asserting `rst` during an operation ends it. `ready` is high in the first cycle after the reset edge, and ordinary reads resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle when high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read result or status word |
| ready | output | 1 | High when idle, low while an operation runs |

## Verification
The hardest case to reach from the ports is a command sequence arriving while an operation is already running. The stimulus covers it by sending the unlock and set-up writes during a program. After `ready` returns high, it sends a single data write: if the busy-time writes had leaked into the decoder, that write would change the target word.

Broken sequences are driven by corrupting each step in turn. The AND rule is swept over all pairs of single-zero-bit patterns, each pair programmed twice into its own word.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int          CMP_AW     = 11;
    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_B = 8'h55;
    localparam logic [7:0]  OPC_WORD   = 8'hA0;
    localparam logic [7:0]  OPC_ARMCLR = 8'h80;
    localparam logic [7:0]  OPC_WHOLE  = 8'h10;

    typedef enum logic [2:0] {
        SQ_READ, SQ_KEY1, SQ_KEY2, SQ_WORD_ARM,
        SQ_CLR_ARM, SQ_CLR_KEY1, SQ_CLR_KEY2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE, OP_PROG, OP_PRECLR, OP_ERASE
    } op_state_t;

    typedef struct packed {
        logic prog;
        logic erase;
    } launch_t;

    function automatic logic cmd_hit(input logic [10:0] a, input logic [7:0] d,
                                     input logic [10:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_decoder.sv
module seq_decoder
    import nor_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [10:0] wr_addr,
    input  logic [7:0]  wr_byte,
    output launch_t     launch
);

    seq_state_t st, nxt;

    always_comb begin
        nxt    = st;
        launch = '0;
        if (wr_en) begin
            case (st)
                SQ_READ:     nxt = cmd_hit(wr_addr, wr_byte, KEY_ADDR_A, KEY_BYTE_A) ? SQ_KEY1 : SQ_READ;
                SQ_KEY1:     nxt = cmd_hit(wr_addr, wr_byte, KEY_ADDR_B, KEY_BYTE_B) ? SQ_KEY2 : SQ_READ;
                SQ_KEY2: begin
                    if (cmd_hit(wr_addr, wr_byte, KEY_ADDR_A, OPC_WORD))
                        nxt = SQ_WORD_ARM;
                    else if (cmd_hit(wr_addr, wr_byte, KEY_ADDR_A, OPC_ARMCLR))
                        nxt = SQ_CLR_ARM;
                    else
                        nxt = SQ_READ;
                end
                SQ_WORD_ARM: begin
                    launch.prog = 1'b1;
                    nxt         = SQ_READ;
                end
                SQ_CLR_ARM:  nxt = cmd_hit(wr_addr, wr_byte, KEY_ADDR_A, KEY_BYTE_A) ? SQ_CLR_KEY1 : SQ_READ;
                SQ_CLR_KEY1: nxt = cmd_hit(wr_addr, wr_byte, KEY_ADDR_B, KEY_BYTE_B) ? SQ_CLR_KEY2 : SQ_READ;
                SQ_CLR_KEY2: begin
                    launch.erase = cmd_hit(wr_addr, wr_byte, KEY_ADDR_A, OPC_WHOLE);
                    nxt          = SQ_READ;
                end
                default:     nxt = SQ_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_READ;
        else     st <= nxt;
    end

    // R8: a wrong second key write abandons the sequence
    p_bad_key_read_r8: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_KEY1 && wr_en && !(wr_addr == KEY_ADDR_B && wr_byte == KEY_BYTE_B))
        |=> st == SQ_READ);

endmodule

// File: rtl/word_array.sv
module word_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fill_ones,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (fill_ones) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/op_engine.sv
module op_engine
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  launch_t           launch,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);

    localparam int WORDS = 1 << ADDR_W;
    localparam int MAXV  = max3(WORDS, PROG_CYCLES, ERASE_CYCLES);
    localparam int CNT_W = $clog2(MAXV + 1);

    op_state_t         op;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] tgt_a;
    logic [DATA_W-1:0] tgt_d;
    logic              tog;

    logic              we, fill_ones;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata, rdata_a, rdata_b, status;

    assign ready     = (op == OP_NONE);
    assign we        = (op == OP_PRECLR) || (op == OP_PROG && cnt == '0);
    assign waddr     = (op == OP_PRECLR) ? cnt[ADDR_W-1:0] : tgt_a;
    assign wdata     = (op == OP_PRECLR) ? '0 : (rdata_b & tgt_d);
    assign fill_ones = (op == OP_ERASE) && (cnt == '0);

    always_comb begin
        status    = '0;
        status[7] = (op == OP_PROG) ? ~tgt_d[7] : 1'b0;
        status[6] = tog;
    end

    word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .fill_ones(fill_ones),
        .raddr_a(rd_addr), .rdata_a(rdata_a), .raddr_b(tgt_a), .rdata_b(rdata_b)
    );

    always_ff @(posedge clk) begin
        if (op == OP_NONE && launch.prog) begin
            tgt_a <= wr_addr;
            tgt_d <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op      <= OP_NONE;
            cnt     <= '0;
            tog     <= 1'b0;
            rd_data <= '0;
        end else begin
            case (op)
                OP_NONE: begin
                    if (launch.prog) begin
                        op  <= OP_PROG;
                        cnt <= CNT_W'(PROG_CYCLES - 1);
                    end else if (launch.erase) begin
                        op  <= OP_PRECLR;
                        cnt <= '0;
                    end
                end
                OP_PROG: begin
                    if (cnt == '0) op <= OP_NONE;
                    else           cnt <= cnt - 1'b1;
                end
                OP_PRECLR: begin
                    if (cnt == CNT_W'(WORDS - 1)) begin
                        op  <= OP_ERASE;
                        cnt <= CNT_W'(ERASE_CYCLES - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                OP_ERASE: begin
                    if (cnt == '0) op <= OP_NONE;
                    else           cnt <= cnt - 1'b1;
                end
                default: op <= OP_NONE;
            endcase
            if (rd_en) begin
                if (op == OP_NONE) begin
                    rd_data <= rdata_a;
                end else begin
                    rd_data <= status;
                    tog     <= ~tog;
                end
            end
        end
    end

    // R3: completed program leaves old AND new in the target word
    p_prog_and_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PROG && cnt == '0) |=> rdata_b == ($past(rdata_b) & tgt_d));

    // R4: the last erase cycle leaves the array at all ones
    p_erase_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ERASE && cnt == '0) |=> rdata_b == '1);

    // R7: back-to-back status reads flip bit 6
    p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && op != OP_NONE && $past(rd_en && op != OP_NONE))
        |=> rd_data[6] != $past(rd_data[6]));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);

    launch_t launch;
    logic    wr_ok;

    assign wr_ok = wr_en && ready;

    seq_decoder i_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_ok),
        .wr_addr(wr_addr[CMP_AW-1:0]), .wr_byte(wr_data[7:0]),
        .launch(launch)
    );

    op_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) i_engine (
        .clk(clk), .rst(rst), .launch(launch),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
    );

    // R9: the decoder never launches while an operation runs
    p_busy_no_launch_r9: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !(launch.prog || launch.erase));

    // R2: a program launch drops ready on the next cycle
    p_prog_busy_r2: assert property (@(posedge clk) disable iff (rst)
        launch.prog |=> !ready);

    // R4: an erase launch drops ready on the next cycle
    p_erase_busy_r4: assert property (@(posedge clk) disable iff (rst)
        launch.erase |=> !ready);

endmodule

// File: tb/test_nor_cmd_ctrl.sv
module test_nor_cmd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int PC = 8;
    localparam int EC = 32;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ready;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    nor_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_nor_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
    endtask

    task automatic erase_all();
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0010);
    endtask

    task automatic wait_ready(input int start, output int elapsed);
        while (!ready) @(negedge clk);
        elapsed = cyc - start;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v, v2;
        int t0, el;

        repeat (3) @(negedge clk);
        chk("R1 ready during reset", ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", ready, 1);

        // R4 erase timing and contents
        erase_all(); t0 = cyc;
        chk("R4 busy after erase", ready, 0);
        rd(11'h003, v);
        chk("R6 erase status bit7", v[7], 0);
        wait_ready(t0, el);
        chk("R4 erase duration", el, WORDS + EC);
        rd(11'h000, v);   chk("R4 word 0 ones", v, 16'hFFFF);
        rd(11'h7FF, v);   chk("R4 last word ones", v, 16'hFFFF);
        rd(11'h555, v);   chk("R4 key word ones", v, 16'hFFFF);

        // R5 R7 status during program
        prog(11'h010, 16'h1234); t0 = cyc;
        rd(11'h010, v); rd(11'h010, v2);
        chk("R5 status bit7 inverted", v[7], 1);
        chk("R5 status other bits", {v[15:8], v[5:0]}, 0);
        chk("R7 bit6 toggles", v[6] ^ v2[6], 1);
        wait_ready(t0, el);
        rd(11'h010, v);   chk("R3 first program", v, 16'h1234);
        prog(11'h011, 16'h00FF);
        rd(11'h011, v);   chk("R5 status bit7 for one", v[7], 0);
        wait_ready(t0, el);

        // R2 duration
        prog(11'h012, 16'hABCD); t0 = cyc;
        chk("R2 busy right after launch", ready, 0);
        wait_ready(t0, el);
        chk("R2 program duration", el, PC);
        rd(11'h012, v);   chk("R1 R2 read back", v, 16'hABCD);

        // R3 sweep of AND rule
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] pa, pb;
                a  = AW'(11'h600 + 16 * i + j);
                pa = ~(16'h0001 << i);
                pb = ~(16'h0001 << j);
                prog(a, pa); t0 = cyc; wait_ready(t0, el);
                prog(a, pb); t0 = cyc; wait_ready(t0, el);
                rd(a, v);
                chk("R3 old AND new", v, pa & pb);
            end
        end

        // R8 broken program sequences
        for (int c = 0; c < 3; c++) begin
            logic [AW-1:0] ka [3];
            logic [DW-1:0] kd [3];
            ka[0] = 11'h555; kd[0] = 16'h00AA;
            ka[1] = 11'h2AA; kd[1] = 16'h0055;
            ka[2] = 11'h555; kd[2] = 16'h00A0;
            if (c == 1) ka[c] = 11'h2AB;
            else        kd[c] = kd[c] ^ 16'h0001;
            for (int k = 0; k < 3; k++) wr(ka[k], kd[k]);
            wr(AW'(11'h020 + c), 16'h0000);
            chk("R8 no launch after bad step", ready, 1);
            rd(AW'(11'h020 + c), v);
            chk("R8 word untouched", v, 16'hFFFF);
        end
        // R8 broken erase sequence at final command
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0030);
        chk("R8 erase not started", ready, 1);
        rd(11'h010, v);   chk("R8 data kept", v, 16'h1234);
        prog(11'h030, 16'h0000); t0 = cyc; wait_ready(t0, el);
        rd(11'h030, v);   chk("R8 decoder back in read mode", v, 16'h0000);

        // R9 writes during a program
        prog(11'h050, 16'hFF00); t0 = cyc;
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
        wait_ready(t0, el);
        chk("R9 duration unchanged", el, PC);
        wr(11'h051, 16'h0000);
        chk("R9 no launch from busy writes", ready, 1);
        rd(11'h051, v);   chk("R9 busy writes ignored", v, 16'hFFFF);
        rd(11'h050, v);   chk("R9 target intact", v, 16'hFF00);

        // R10 reset during program and erase
        prog(11'h060, 16'h0000);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 ready after reset in program", ready, 1);
        rd(11'h012, v);   chk("R10 read mode resumes", v, 16'hABCD);
        erase_all();
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 ready after reset in erase", ready, 1);
        rd(11'h7FF, v);   chk("R10 untouched word after erase reset", v, 16'hFFFF);
        prog(11'h7F0, 16'h5A5A); t0 = cyc; wait_ready(t0, el);
        chk("R10 program after reset duration", el, PC);
        rd(11'h7F0, v);   chk("R10 program after reset", v, 16'h5A5A);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule